// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Front End

This block sits in front of a synchronous burst memory array and turns its sampled control pins into a registered memory address, a device-selected flag and a read or write qualifier. Two active-low address strobes compete for the address register: one driven by a processor and one by a memory controller. Three chip enables decide whether the device is selected. An advance input steps a small burst counter that supplies the lowest address bits during a burst.

A new address is taken only in a load cycle. That is a cycle in which the processor strobe is effective, or in which the controller strobe is low. In that same cycle the chip enables are evaluated. In every other cycle they are ignored, and the select state carries over. The counter wraps in linear order inside an aligned group, so the upper address bits stay fixed for the whole burst. All outputs are registered and change on the clock edge after the cycle that caused them.

Top module: `bsr_addr_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `selected`=0, `rd_cycle`=0, `wr_cycle`=0 and `mem_addr`=0.
- R2: A processor strobe (`proc_strobe_n`=0) with all enables active (`en0_n`=0, `en1`=1, `en2_n`=0) loads `addr_in` into `mem_addr` and sets `selected`=1, `rd_cycle`=1 and `wr_cycle`=0 on the next edge. This holds whatever the write enables are.
- R3: A controller strobe load (`ctrl_strobe_n`=0, with the processor strobe not effective and all enables active) captures `addr_in`. The cycle is a write (`wr_cycle`=1, `rd_cycle`=0) when `gw_n`=0, or when `bwe_n`=0 and at least one bit of `bw_n` is 0. Otherwise it is a read. `rd_cycle` and `wr_cycle` are never both 1.
- R4: When both strobes are low and `en0_n`=0, only the processor strobe is taken, so the cycle is a read even if write enables are active.
- R5: With `en0_n`=1 the processor strobe is ignored. If `ctrl_strobe_n`=1, then `mem_addr`, `selected` and the cycle type stay unchanged.
- R6: A load cycle whose enables are not all active gives `selected`=0, `rd_cycle`=0 and `wr_cycle`=0. `mem_addr` keeps its value and the counter does not advance in that cycle.
- R7: In cycles without a load, the chip enables have no effect, and `selected` keeps its value.
- R8: In a cycle without a load, `adv_n`=0 increments the low `BURST_W` bits of `mem_addr` by one modulo 2^`BURST_W` (3 wraps to 0 by default). The upper bits stay unchanged.
- R9: With no load and `adv_n`=1, `mem_addr`, `selected` and the cycle type hold.
- R10: In a load cycle, `adv_n` is ignored, and `mem_addr` equals the new `addr_in` without any increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| en0_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| en1 | input | 1 | Second chip enable, active high |
| en2_n | input | 1 | Third chip enable, active low |
| adv_n | input | 1 | Burst advance request, active low |
| gw_n | input | 1 | Write-all-bytes enable, active low |
| bwe_n | input | 1 | Byte write qualifier, active low |
| bw_n | input | BYTES | Per-byte write selects, active low |
| addr_in | input | ADDR_W | External address |
| mem_addr | output | ADDR_W | Current array address |
| selected | output | 1 | Device selected by the last load |
| rd_cycle | output | 1 | Selected read cycle in progress |
| wr_cycle | output | 1 | Selected write cycle in progress |

## Verification
Each piece of state shows up directly at a port one edge after it is updated. A wrong counter value shows in the low bits of `mem_addr` on the first advance. A lost or stale upper field shows in the high bits. A select flag that tracks the enables outside load cycles, or a wrong strobe priority, shows as a wrong `selected`, `rd_cycle` or `wr_cycle` on the next edge. The directed scenarios therefore sample one cycle after each stimulus, walk the counter through its wrap, and toggle enables and write enables in non-load cycles to catch leaks.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } bsr_src_e;
endpackage

// File: rtl/bsr_strobe_decode.sv
module bsr_strobe_decode
    import bsr_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             en0_n,
    input  logic             en1,
    input  logic             en2_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [BYTES-1:0] bw_n,
    output bsr_src_e         src,
    output logic             load,
    output logic             enables_ok,
    output logic             wr_req
);
    logic any_byte;

    always_comb begin
        // processor strobe counts only while the first enable is active
        if (!proc_strobe_n && !en0_n) begin
            src = SRC_PROC;
        end else if (!ctrl_strobe_n) begin
            src = SRC_CTRL;
        end else begin
            src = SRC_NONE;
        end
        load       = (src != SRC_NONE);
        enables_ok = !en0_n && en1 && !en2_n;
        any_byte   = !bwe_n && !(&bw_n);
        wr_req     = (src == SRC_CTRL) && (!gw_n || any_byte);
    end
endmodule

// File: rtl/bsr_burst_counter.sv
module bsr_burst_counter #(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BURST_W-1:0] load_val,
    input  logic               adv,
    output logic [BURST_W-1:0] cnt
);
    logic [BURST_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (adv) begin
            cnt_d = cnt_q + 1'b1; // linear order, wraps naturally
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bsr_addr_ctrl.sv
module bsr_addr_ctrl
    import bsr_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2,
    parameter int BYTES   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              en2_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [BYTES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              selected,
    output logic              rd_cycle,
    output logic              wr_cycle
);
    localparam int UPPER_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic               sel;
        logic               is_wr;
    } front_state_t;

    front_state_t st_d, st_q;

    bsr_src_e           src;
    logic               load, enables_ok, wr_req;
    logic               cnt_load, cnt_adv;
    logic [BURST_W-1:0] cnt;

    bsr_strobe_decode #(.BYTES(BYTES)) u_dec (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .en0_n         (en0_n),
        .en1           (en1),
        .en2_n         (en2_n),
        .gw_n          (gw_n),
        .bwe_n         (bwe_n),
        .bw_n          (bw_n),
        .src           (src),
        .load          (load),
        .enables_ok    (enables_ok),
        .wr_req        (wr_req)
    );

    bsr_burst_counter #(.BURST_W(BURST_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (addr_in[BURST_W-1:0]),
        .adv      (cnt_adv),
        .cnt      (cnt)
    );

    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_adv  = 1'b0;
        if (load) begin
            if (enables_ok) begin
                st_d.upper = addr_in[ADDR_W-1:BURST_W];
                st_d.sel   = 1'b1;
                st_d.is_wr = wr_req;
                cnt_load   = 1'b1;
            end else begin
                st_d.sel   = 1'b0;
                st_d.is_wr = 1'b0;
            end
        end else if (!adv_n) begin
            cnt_adv = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr = {st_q.upper, cnt};
    assign selected = st_q.sel;
    assign rd_cycle = st_q.sel && !st_q.is_wr;
    assign wr_cycle = st_q.sel && st_q.is_wr;
endmodule

// File: rtl/bsr_addr_ctrl_chk.sv
module bsr_addr_ctrl_chk #(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2,
    parameter int BYTES   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              en0_n,
    input logic              en1,
    input logic              en2_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              bwe_n,
    input logic [BYTES-1:0]  bw_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              selected,
    input logic              rd_cycle,
    input logic              wr_cycle
);
    logic p_take, c_take, ld, en_all, wr_en;
    assign p_take = !proc_strobe_n && !en0_n;
    assign c_take = !p_take && !ctrl_strobe_n;
    assign ld     = p_take || !ctrl_strobe_n;
    assign en_all = !en0_n && en1 && !en2_n;
    assign wr_en  = !gw_n || (!bwe_n && (bw_n != {BYTES{1'b1}}));

    AST_RESET_DESEL: assert property (@(posedge clk) rst |=> (!selected && !rd_cycle && !wr_cycle)); // R1
    AST_PROC_READ: assert property (@(posedge clk) disable iff (rst)
        (p_take && en_all) |=> (selected && rd_cycle && !wr_cycle && mem_addr == $past(addr_in))); // R2
    AST_CTRL_TYPE: assert property (@(posedge clk) disable iff (rst)
        (c_take && en_all) |=> (wr_cycle == $past(wr_en) && mem_addr == $past(addr_in))); // R3
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst) !(rd_cycle && wr_cycle)); // R3
    AST_DESEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld && !en_all) |=> (!selected && !rd_cycle && !wr_cycle && $stable(mem_addr))); // R6
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(selected)); // R7
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv_n) |=> (mem_addr[BURST_W-1:0] == BURST_W'($past(mem_addr[BURST_W-1:0]) + 1'b1)
            && mem_addr[ADDR_W-1:BURST_W] == $past(mem_addr[ADDR_W-1:BURST_W]))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv_n) |=> ($stable(mem_addr) && $stable(rd_cycle) && $stable(wr_cycle))); // R9
endmodule

bind bsr_addr_ctrl bsr_addr_ctrl_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .BYTES(BYTES)) u_chk (.*);

// File: tb/sim_bsr_addr_ctrl.sv
module sim_bsr_addr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 18;
    localparam int BURST_W    = 2;
    localparam int BYTES      = 4;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1;
    logic              en0_n = 1'b1, en1 = 1'b0, en2_n = 1'b1;
    logic              adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1;
    logic [BYTES-1:0]  bw_n = '1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              selected, rd_cycle, wr_cycle;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsr_addr_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .BYTES(BYTES)) u0 (
        .clk(clk), .rst(rst), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .addr_in(addr_in), .mem_addr(mem_addr),
        .selected(selected), .rd_cycle(rd_cycle), .wr_cycle(wr_cycle)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    endtask

    task automatic enables(input logic e0n, input logic e1, input logic e2n);
        en0_n = e0n; en1 = e1; en2_n = e2n;
    endtask

    task automatic state_is(input string req, input logic [ADDR_W-1:0] a,
                            input logic s, input logic r, input logic w);
        chk({req, " mem_addr"}, 32'(mem_addr), 32'(a));
        chk({req, " selected"}, 32'(selected), 32'(s));
        chk({req, " rd_cycle"}, 32'(rd_cycle), 32'(r));
        chk({req, " wr_cycle"}, 32'(wr_cycle), 32'(w));
    endtask

    task automatic t_reset();
        idle(); rst = 1'b1;
        tick(); tick();
        state_is("R1 reset", '0, 0, 0, 0);
        rst = 1'b0;
    endtask

    task automatic t_proc_read();
        idle(); enables(0, 1, 0);
        addr_in = 18'h1234D; proc_strobe_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bw_n = '0;
        tick(); idle();
        state_is("R2 proc read", 18'h1234D, 1, 1, 0);
    endtask

    task automatic t_ctrl_types();
        enables(0, 1, 0);
        addr_in = 18'h00A01; ctrl_strobe_n = 1'b0; gw_n = 1'b0;
        tick(); idle();
        state_is("R3 ctrl global write", 18'h00A01, 1, 0, 1);
        addr_in = 18'h00B02; ctrl_strobe_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1011;
        tick(); idle();
        state_is("R3 ctrl byte write", 18'h00B02, 1, 0, 1);
        addr_in = 18'h00C03; ctrl_strobe_n = 1'b0; bwe_n = 1'b1; bw_n = 4'b0000;
        tick(); idle();
        state_is("R3 ctrl read no bwe", 18'h00C03, 1, 1, 0);
        addr_in = 18'h00D00; ctrl_strobe_n = 1'b0; bwe_n = 1'b0; bw_n = '1;
        tick(); idle();
        state_is("R3 ctrl read no byte", 18'h00D00, 1, 1, 0);
    endtask

    task automatic t_priority();
        enables(0, 1, 0);
        addr_in = 18'h3FFF1; proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; gw_n = 1'b0;
        tick(); idle();
        state_is("R4 proc over ctrl", 18'h3FFF1, 1, 1, 0);
    endtask

    task automatic t_proc_ignored();
        enables(0, 1, 0);
        addr_in = 18'h05550; ctrl_strobe_n = 1'b0; gw_n = 1'b0;
        tick(); idle();
        state_is("R5 setup", 18'h05550, 1, 0, 1);
        enables(1, 1, 0);
        addr_in = 18'h2AAA3; proc_strobe_n = 1'b0;
        tick(); idle();
        state_is("R5 proc ignored", 18'h05550, 1, 0, 1);
    endtask

    task automatic t_deselect();
        enables(0, 1, 0);
        addr_in = 18'h11111; proc_strobe_n = 1'b0;
        tick(); idle();
        enables(0, 0, 0);
        addr_in = 18'h22222; proc_strobe_n = 1'b0; adv_n = 1'b0;
        tick(); idle();
        state_is("R6 desel en1", 18'h11111, 0, 0, 0);
        enables(0, 1, 0);
        addr_in = 18'h11111; proc_strobe_n = 1'b0;
        tick(); idle();
        enables(1, 1, 1);
        addr_in = 18'h33333; ctrl_strobe_n = 1'b0; gw_n = 1'b0;
        tick(); idle();
        state_is("R6 desel ctrl", 18'h11111, 0, 0, 0);
    endtask

    task automatic t_enables_ignored();
        enables(0, 1, 0);
        addr_in = 18'h04444; ctrl_strobe_n = 1'b0; gw_n = 1'b0;
        tick(); idle();
        enables(1, 0, 1);
        tick();
        state_is("R7 enables off no load", 18'h04444, 1, 0, 1);
        enables(0, 1, 0);
        tick();
        state_is("R7 enables on no load", 18'h04444, 1, 0, 1);
    endtask

    task automatic t_advance_wrap();
        enables(0, 1, 0);
        addr_in = 18'h2A5F2; proc_strobe_n = 1'b0;
        tick(); idle();
        adv_n = 1'b0;
        tick();
        chk("R8 adv step", 32'(mem_addr), 32'h2A5F3);
        tick();
        chk("R8 adv wrap", 32'(mem_addr), 32'h2A5F0);
        tick();
        chk("R8 adv after wrap", 32'(mem_addr), 32'h2A5F1);
        chk("R8 sel kept", 32'(rd_cycle), 32'd1);
        idle();
    endtask

    task automatic t_hold();
        enables(0, 1, 0);
        addr_in = 18'h01237; ctrl_strobe_n = 1'b0; gw_n = 1'b0;
        tick(); idle();
        addr_in = 18'h3C3C3; gw_n = 1'b0;
        tick(); tick();
        state_is("R9 hold", 18'h01237, 1, 0, 1);
    endtask

    task automatic t_load_over_adv();
        enables(0, 1, 0);
        addr_in = 18'h09999; proc_strobe_n = 1'b0;
        tick(); idle();
        addr_in = 18'h1ABC1; ctrl_strobe_n = 1'b0; adv_n = 1'b0;
        tick(); idle();
        state_is("R10 load over adv", 18'h1ABC1, 1, 1, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_proc_read();
        t_ctrl_types();
        t_priority();
        t_proc_ignored();
        t_deselect();
        t_enables_ignored();
        t_advance_wrap();
        t_hold();
        t_load_over_adv();
        rst = 1'b1;
        tick();
        state_is("R1 late reset", '0, 0, 0, 0);
        finish_run();
    end
endmodule